// File: doc/BRIEF.md
# Interleaved Multi-Bank Word Memory

This block sits between a vector load/store stream and a set of word-wide storage banks. Word addresses are spread across `NB` banks. The low address bits select the bank and the remaining bits select the row inside it. Each bank keeps its own timer for occupancy, so accesses to different banks overlap. An access to one bank blocks that bank for `LAT` cycles.

The requester offers at most one request per cycle with a valid/ready handshake. A request whose bank is still occupied sees `req_ready_o` low and is held until the bank frees up. Every cycle in which a valid request is held back adds one to a stall counter. Reads return their data with the request tag exactly `LAT` cycles after acceptance, so responses arrive in request order. Writes return nothing.

When `NB >= LAT`, a unit-stride stream flows at one word per clock. A stride that keeps landing on the same bank issues one word every `LAT` cycles.

Top module: `mbank_mem`

## Requirements
- R1: Word address `a` is stored in bank `a % NB` at row `a / NB`. A read of `a` returns the value of the last write to `a`.
- R2: After a request to bank `b` is accepted in cycle `c`, `req_ready_o` is low in cycles `c+1` .. `c+LAT-1` whenever the presented address maps to bank `b`. It is high again from cycle `c+LAT`. `req_ready_o` depends on the presented address, not on `req_valid_i`.
- R3: An address that maps to a bank not accessed in the last `LAT` cycles is accepted at once, even while other banks are occupied.
- R4: A read accepted in cycle `c` produces `rsp_valid_o` high for exactly one cycle, in cycle `c+LAT`. In that cycle `rsp_tag_o` carries the request tag and `rsp_rdata_o` carries the read data. Responses come back in acceptance order.
- R5: An accepted write (`req_we_i = 1`) produces no response.
- R6: `stall_cnt_o` increases by one after each cycle in which `req_valid_i` is high and `req_ready_o` is low. Otherwise it holds its value.
- R7: After reset, `req_ready_o` is high for every address, `rsp_valid_o` is low, `stall_cnt_o` is zero, and every word reads as zero.
- R8: With `NB >= LAT`, a unit-stride stream of `n` requests is accepted in `n` consecutive cycles without any stall.
- R9: A stream whose stride is a multiple of `NB` stalls `LAT-1` cycles before each request after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Addressed bank can accept this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | $clog2(WORDS) | Word address |
| req_wdata_i | input | DW | Write data |
| req_tag_i | input | TW | Request tag, returned with read data |
| rsp_valid_o | output | 1 | Read response present |
| rsp_tag_o | output | TW | Tag of the answered read |
| rsp_rdata_o | output | DW | Read data |
| stall_cnt_o | output | CW | Cycles lost to occupied banks |

## Verification
The bank-hold property assumes `LAT` is at least two. It also assumes the requester may change the address while stalled; the property follows the bank of whatever address is presented. The stall-counter properties assume the counter never wraps within a run. The stimulus stays far below `2**CW` stall cycles. The bench walks the full address space at several strides and then runs a mixed read/write sequence with idle gaps. It predicts ready, responses and stall counts from per-bank acceptance times and a word model of its own.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/mbank_bank.sv
module mbank_bank #(
  parameter int DW   = 16,
  parameter int ROWS = 8,
  parameter int LAT  = 6,
  localparam int RW   = $clog2(ROWS),
  localparam int CNTW = $clog2(LAT) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [RW-1:0] row_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          free_o
);
  import mbank_pkg::*;

  logic [DW-1:0]   mem_q [ROWS];
  logic [CNTW-1:0] busy_q;
  mem_op_e         op;

  assign op      = mem_op_e'(we_i);
  assign free_o  = (busy_q == '0);
  assign rdata_o = mem_q[row_i];

  // load LAT-1 so the same bank is accepted again LAT cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else if (sel_i) busy_q <= CNTW'(LAT - 1);
    else if (busy_q != '0) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (sel_i && op == OP_WRITE) begin
      mem_q[row_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/mbank_rsp_pipe.sv
module mbank_rsp_pipe #(
  parameter int W   = 20,
  parameter int LAT = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic         vld_q [LAT];
  logic [W-1:0] dat_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end else if (s == 0) begin
        vld_q[s] <= vld_i;
        dat_q[s] <= dat_i;
      end else begin
        vld_q[s] <= vld_q[(s == 0) ? 0 : s-1];
        dat_q[s] <= dat_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign dat_o = dat_q[LAT-1];
endmodule

// File: rtl/mbank_mem.sv
module mbank_mem #(
  parameter int DW    = 16,
  parameter int NB    = 8,
  parameter int LAT   = 6,
  parameter int WORDS = 64,
  parameter int TW    = 4,
  parameter int CW    = 16,
  localparam int AW   = $clog2(WORDS),
  localparam int BW   = $clog2(NB),
  localparam int ROWS = WORDS / NB,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [TW-1:0] req_tag_i,
  output logic          rsp_valid_o,
  output logic [TW-1:0] rsp_tag_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [CW-1:0] stall_cnt_o
);
  logic [BW-1:0] bank_sel;
  logic [RW-1:0] row_sel;
  logic [NB-1:0] bank_free, bank_hit;
  logic [DW-1:0] bank_rdata [NB];
  logic          accept;
  logic [CW-1:0] stall_q;

  assign bank_sel    = req_addr_i[BW-1:0];
  assign row_sel     = req_addr_i[AW-1:BW];
  assign req_ready_o = bank_free[bank_sel];
  assign accept      = req_valid_i && req_ready_o;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_hit[b] = accept && (bank_sel == BW'(b));
    mbank_bank #(.DW(DW), .ROWS(ROWS), .LAT(LAT)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (bank_hit[b]),
      .we_i    (req_we_i),
      .row_i   (row_sel),
      .wdata_i (req_wdata_i),
      .rdata_o (bank_rdata[b]),
      .free_o  (bank_free[b])
    );
  end

  mbank_rsp_pipe #(.W(TW + DW), .LAT(LAT)) i_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (accept && !req_we_i),
    .dat_i  ({req_tag_i, bank_rdata[bank_sel]}),
    .vld_o  (rsp_valid_o),
    .dat_o  ({rsp_tag_o, rsp_rdata_o})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= '0;
    else if (req_valid_i && !req_ready_o) stall_q <= stall_q + 1'b1;
  end

  assign stall_cnt_o = stall_q;
endmodule

// File: rtl/mbank_mem_chk.sv
module mbank_mem_chk #(
  parameter int NB  = 8,
  parameter int LAT = 6,
  parameter int CW  = 16,
  localparam int BW = $clog2(NB)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_we_i,
  input logic [BW-1:0] bank_i,
  input logic          rsp_valid_o,
  input logic [CW-1:0] stall_cnt_o
);
  logic [LAT-1:0] rd_hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_hist_q <= '0;
    else rd_hist_q <= {rd_hist_q[LAT-2:0], req_valid_i && req_ready_o && !req_we_i};
  end

  // R4 and R5: a response marks exactly the reads accepted LAT cycles earlier
  a_r4_rsp_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == rd_hist_q[LAT-1]);

  a_r2_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (bank_i != $past(bank_i)) || !req_ready_o);

  a_r6_stall_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1);

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_ready_o) |=> $stable(stall_cnt_o));
endmodule

bind mbank_mem mbank_mem_chk #(.NB(NB), .LAT(LAT), .CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_we_i    (req_we_i),
  .bank_i      (req_addr_i[$clog2(NB)-1:0]),
  .rsp_valid_o (rsp_valid_o),
  .stall_cnt_o (stall_cnt_o)
);

// File: tb/test_mbank_mem.sv
`timescale 1ns/1ps
module test_mbank_mem;
  localparam int DW = 16, NB = 8, LAT = 6, WORDS = 64, TW = 4, CW = 16;
  localparam int QN = 4096;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [5:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [TW-1:0] req_tag_i = '0;
  logic req_ready_o, rsp_valid_o;
  logic [TW-1:0] rsp_tag_o;
  logic [DW-1:0] rsp_rdata_o;
  logic [CW-1:0] stall_cnt_o;

  always #2.5 clk_i = ~clk_i;

  mbank_mem #(.DW(DW), .NB(NB), .LAT(LAT), .WORDS(WORDS), .TW(TW), .CW(CW)) i_mbank_mem (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i,
    .req_wdata_i, .req_tag_i, .rsp_valid_o, .rsp_tag_o, .rsp_rdata_o, .stall_cnt_o
  );

  int checks = 0, fails = 0, cyc = 0, stall_exp = 0;
  int last_acc [NB];
  logic [DW-1:0] mdl [WORDS];
  int q_due [QN];
  logic [TW-1:0] q_tag [QN];
  logic [DW-1:0] q_dat [QN];
  int qh = 0, qt = 0;
  logic [TW-1:0] tag_n = '0;
  int seed = 12345;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // called at a falling edge; checks registered outputs, then advances one cycle
  task automatic tick(input bit stalled);
    bit exp_v;
    exp_v = (qh < qt) && (q_due[qh] == cyc);
    chk(rsp_valid_o == exp_v, "R4", "rsp_valid", int'(rsp_valid_o), int'(exp_v));
    if (exp_v && rsp_valid_o) begin
      chk(rsp_tag_o == q_tag[qh], "R4", "rsp_tag", int'(rsp_tag_o), int'(q_tag[qh]));
      chk(rsp_rdata_o == q_dat[qh], "R1", "rsp_rdata", int'(rsp_rdata_o), int'(q_dat[qh]));
    end
    if (exp_v) qh++;
    chk(int'(stall_cnt_o) == stall_exp, "R6", "stall_cnt", int'(stall_cnt_o), stall_exp);
    @(posedge clk_i);
    cyc++;
    if (stalled) stall_exp++;
    @(negedge clk_i);
  endtask

  task automatic issue(input bit we, input int addr, input logic [DW-1:0] d);
    bit acc, exp_r;
    int b;
    b = addr % NB;
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = 6'(addr);
    req_wdata_i = d; req_tag_i = tag_n;
    acc = 1'b0;
    while (!acc) begin
      #1;
      exp_r = (cyc - last_acc[b]) >= LAT;
      chk(req_ready_o == exp_r, "R2", "ready", int'(req_ready_o), int'(exp_r));
      acc = req_ready_o;
      if (acc) begin
        last_acc[b] = cyc;
        if (we) mdl[addr] = d;
        else begin
          q_due[qt] = cyc + LAT; q_tag[qt] = tag_n; q_dat[qt] = mdl[addr]; qt++;
        end
        tag_n++;
      end
      tick(!acc);
    end
    req_valid_i = 1'b0;
  endtask

  task automatic idle(input int n, input int addr);
    bit exp_r;
    req_valid_i = 1'b0; req_addr_i = 6'(addr);
    for (int i = 0; i < n; i++) begin
      #1;
      exp_r = (cyc - last_acc[addr % NB]) >= LAT;
      chk(req_ready_o == exp_r, "R2", "ready while idle", int'(req_ready_o), int'(exp_r));
      tick(1'b0);
    end
  endtask

  task automatic stream(input bit we, input int start, input int stride, input int n,
                        input string rq, input int exp_stall, input int exp_cyc);
    int s0, c0;
    s0 = stall_exp; c0 = cyc;
    for (int i = 0; i < n; i++) begin
      issue(we, (start + i * stride) % WORDS, DW'((start + i) * 16'h3b1 ^ 16'h5a5a));
    end
    chk(stall_exp - s0 == exp_stall, rq, "stream stalls", stall_exp - s0, exp_stall);
    if (exp_cyc >= 0) chk(cyc - c0 == exp_cyc, rq, "stream cycles", cyc - c0, exp_cyc);
    idle(LAT + 2, 0);
    chk(qh == qt, "R4", "responses drained", qh, qt);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) last_acc[b] = -1000;
    for (int a = 0; a < WORDS; a++) mdl[a] = '0;
    repeat (3) @(negedge clk_i);
    // R7: reset state
    chk(rsp_valid_o == 1'b0, "R7", "rsp_valid in reset", int'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(stall_cnt_o == '0, "R7", "stall after reset", int'(stall_cnt_o), 0);
    for (int a = 0; a < NB; a++) begin
      req_addr_i = 6'(a); #1;
      chk(req_ready_o == 1'b1, "R7", "ready after reset", int'(req_ready_o), 1);
    end
    // R7 and R8: all words read zero, unit stride at full rate
    stream(1'b0, 0, 1, WORDS, "R8", 0, WORDS);
    // R1 and R8: fill every word, then read back
    stream(1'b1, 0, 1, WORDS, "R8", 0, WORDS);
    stream(1'b0, 0, 1, WORDS, "R1", 0, WORDS);
    // R9: stride equal to the bank count, and a wider multiple
    stream(1'b0, 3, NB, 8, "R9", 7 * (LAT - 1), -1);
    stream(1'b0, 5, 2 * NB, 4, "R9", 3 * (LAT - 1), -1);
    // stride 2 uses 4 banks: 2 lost cycles per round after the first
    stream(1'b0, 0, 2, 16, "R2", 6, 22);
    // R3: odd stride visits every bank, no stall
    stream(1'b0, 1, 3, WORDS, "R3", 0, WORDS);
    // R5: writes alone produce no response
    stream(1'b1, 7, 5, 20, "R5", 0, 20);
    // R6: busy bank addressed with valid low adds no stall
    issue(1'b1, 9, 16'h1234);
    idle(4, 17);
    issue(1'b0, 17, '0);
    issue(1'b0, 9, '0);
    idle(LAT + 2, 0);
    // mixed reads and writes with gaps
    for (int i = 0; i < 300; i++) begin
      int a;
      bit w;
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 8) & (WORDS - 1);
      w = seed[20];
      issue(w, a, DW'(seed >>> 4));
      if (seed[23:22] == 2'b00) idle(seed[26:25] + 1, a);
    end
    idle(LAT + 2, 0);
    chk(qh == qt, "R4", "final drain", qh, qt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule